// File: doc/BRIEF.md
# Crate Backplane Slave Decoder with Board Select

This block sits on the translator card of a crate that hangs off a VME-style parallel backplane. It watches every bus cycle and accepts a cycle only if it is a full 32-bit transfer in the memory address-modifier space. The cycle must also carry this crate's number in a selectable five-bit group of the upper address lines. It answers with DTACK only for cycles it accepts. All other cycles get no answer, so the master's own bus timeout ends them.

Boards inside the crate are not reached through address bits. A select register of one bit per board (sixteen front-end cards, the trigger card and the translator) chooses which boards take part in a cycle. The block drives one select strobe per board for the length of an accepted cycle. The lowest four register words always belong to the translator, whatever the mask holds, so the mask can be rewritten at any time. Setting several mask bits lets one write reach many boards at once, for example to load identical configuration streams or DAC values. No hardware check stops this. A read while several boards are selected sets a sticky warning flag.

All inputs are taken as already synchronous to `clk`. Bus signals keep their active-low backplane sense. The block carries no data stream, so it has no valid/ready interface. The bus handshake (strobes in, DTACK out) is its only flow control.

Top module: `crate_slave_decoder`

## Requirements
- R1: A cycle starts at the first clock edge where `as_n` is low and at least one data strobe is low. It is qualified only if at that edge `lword_n`, `ds0_n` and `ds1_n` are all low and `addr[1]` is 0. An unqualified cycle gets no DTACK until `as_n` returns high.
- R2: A cycle is qualified only if `am` equals 6'h09 at its start. Any other code is ignored: no DTACK and no register change.
- R3: The crate field is `addr[22+p+4 : 22+p]`, where p is `field_pos` and values above 5 count as 5. The cycle is qualified only if this field equals `crate_id`.
- R4: On an accepted cycle, `dtack_n` goes low at the clock edge after the start and stays low while both data strobes stay low. It goes high at the first edge at which either strobe is seen high.
- R5: The select mask (18 bits, bit 16 = trigger, bit 17 = translator, bits 15..0 = front-end cards) is at word offset 0 (`addr[21:2]`). It resets to zero and reads back what was written in bits 17..0.
- R6: Word offsets 0 to 3 always decode to translator registers, whatever the mask holds. Such cycles are acknowledged and drive no board strobe.
- R7: The clock-control word (offset 0x100) and the high-voltage word (offset 0x101) answer only while mask bit 17 is set. Otherwise they get no DTACK and a write has no effect. They drive no board strobe.
- R8: Any other offset is a board cycle. It is acknowledged only if the mask is nonzero. During DTACK, `board_sel` equals the mask, and it is zero at all other times.
- R9: With several mask bits set, a single board write strobes every selected board in the same cycle.
- R10: A board read with two or more mask bits set sets bit 0 of the status word (offset 1). The bit stays set until a write to offset 1 with data bit 0 = 1.
- R11: Offset 2 is a 32-bit read/write scratch word. Offset 3 reads the number of set mask bits. `rdata` shows the addressed translator word while DTACK is low and is zero otherwise, and also zero on board cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crate_id | input | 5 | This crate's configured number |
| field_pos | input | 3 | Position of the crate field above A22 (0..5) |
| addr | input | 31 | Address lines A31..A1 |
| am | input | 6 | Address modifier |
| as_n | input | 1 | Address strobe, active low |
| ds0_n | input | 1 | Data strobe 0, active low |
| ds1_n | input | 1 | Data strobe 1, active low |
| lword_n | input | 1 | Longword transfer, active low |
| write_n | input | 1 | Low for write, high for read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data from translator words |
| dtack_n | output | 1 | Data acknowledge, active low |
| board_sel | output | 18 | Per-board select strobes |

## Verification
A wrong mask or a wrong decode target shows up at `board_sel` and `dtack_n` one clock after the start of the next cycle that touches it. A missing answer is as visible as a spurious one. A corrupted mask also shows at once in the offset 0 readback and the offset 3 population count. A lost or spurious sticky flag stays hidden until the status word is read. So the directed tests read status right after each board read, and again after unrelated cycles.

// File: rtl/crate_dec_pkg.sv
package crate_dec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACK,
    ST_DRAIN
  } bus_state_e;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_LOCAL,
    TGT_UPPER,
    TGT_BOARDS
  } target_e;

endpackage

// File: rtl/cycle_qualify.sv
module cycle_qualify
  import crate_dec_pkg::*;
#(
  parameter int          NB         = 18,
  parameter int          FIELD_W    = 5,
  parameter int          FIELD_BASE = 22,
  parameter int          FIELD_SPAN = 10,
  parameter logic [5:0]  AM_CODE    = 6'h09,
  parameter int          LOCAL_REGS = 4,
  parameter int          OFS_W      = FIELD_BASE - 2,
  parameter logic [OFS_W-1:0] CLK_OFS = 'h100,
  parameter logic [OFS_W-1:0] HV_OFS  = 'h101
) (
  input  logic [31:1]        addr,
  input  logic [5:0]         am,
  input  logic               lword_n,
  input  logic               ds0_n,
  input  logic               ds1_n,
  input  logic [FIELD_W-1:0] crate_id,
  input  logic [2:0]         field_pos,
  input  logic [NB-1:0]      sel_mask,
  output logic               qual_ok,
  output target_e            target,
  output logic [OFS_W-1:0]   offset
);
  localparam int MAX_POS = FIELD_SPAN - FIELD_W;

  logic [FIELD_SPAN-1:0] hi_bits;
  logic [FIELD_W-1:0]    cand [MAX_POS+1];
  logic [2:0]            pos_eff;
  logic [FIELD_W-1:0]    field;
  logic                  crate_hit;
  logic                  xfer_ok;

  assign hi_bits = addr[FIELD_BASE+FIELD_SPAN-1:FIELD_BASE];
  assign offset  = addr[FIELD_BASE-1:2];

  // one candidate field per legal position
  for (genvar p = 0; p <= MAX_POS; p++) begin : g_field
    assign cand[p] = hi_bits[p +: FIELD_W];
  end

  always_comb begin
    pos_eff = (int'(field_pos) > MAX_POS) ? 3'(MAX_POS) : field_pos;
    field   = cand[pos_eff];
  end

  assign crate_hit = (field == crate_id);
  assign xfer_ok   = !lword_n && !ds0_n && !ds1_n && !addr[1];
  assign qual_ok   = xfer_ok && (am == AM_CODE) && crate_hit;

  always_comb begin
    if (int'(offset) < LOCAL_REGS)
      target = TGT_LOCAL;
    else if (offset == CLK_OFS || offset == HV_OFS)
      target = sel_mask[NB-1] ? TGT_UPPER : TGT_NONE;
    else
      target = (|sel_mask) ? TGT_BOARDS : TGT_NONE;
  end

endmodule

// File: rtl/bus_cycle_fsm.sv
module bus_cycle_fsm
  import crate_dec_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    as_n,
  input  logic    ds0_n,
  input  logic    ds1_n,
  input  logic    qual_ok,
  input  target_e target,
  output logic    start,
  output logic    accept,
  output logic    ack_active,
  output target_e tgt_q
);
  bus_state_e state_q, state_d;

  assign start  = (state_q == ST_IDLE) && !as_n && (!ds0_n || !ds1_n);
  assign accept = start && qual_ok && (target != TGT_NONE);
  assign ack_active = (state_q == ST_ACK);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_ACK;
                else if (start) state_d = ST_DRAIN;
      ST_ACK:   if (ds0_n || ds1_n) state_d = as_n ? ST_IDLE : ST_DRAIN;
      ST_DRAIN: if (as_n) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= TGT_NONE;
    end else begin
      state_q <= state_d;
      if (accept) tgt_q <= target;
    end
  end

  // DTACK may only be held while both strobes were low on the previous edge
  assert_ack_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_active |-> $past(!ds0_n && !ds1_n));

  // a strobe seen high ends the acknowledge at that edge
  assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_active && (ds0_n || ds1_n)) |=> !ack_active);

  // an unaccepted start never leads to an acknowledge before as_n rises
  assert_reject_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && !as_n) |=> !ack_active);

endmodule

// File: rtl/crate_local_regs.sv
module crate_local_regs
  import crate_dec_pkg::*;
#(
  parameter int NB     = 18,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 20,
  parameter logic [OFS_W-1:0] HV_OFS = 'h101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  target_e           target,
  input  logic [OFS_W-1:0]  offset,
  input  logic              write_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [NB-1:0]     sel_mask,
  output logic [DATA_W-1:0] rd_q
);
  localparam int CNT_W = $clog2(NB + 1);

  logic [NB-1:0]     sel_q;
  logic              sticky_q;
  logic [DATA_W-1:0] scratch_q, clk_ctl_q, hv_ctl_q;
  logic [CNT_W-1:0]  sel_cnt;
  logic              wr_local, wr_upper, rd_board;
  logic              sticky_set, sticky_clr;
  logic [DATA_W-1:0] rd_d;

  assign sel_mask = sel_q;
  assign sel_cnt  = CNT_W'($countones(sel_q));

  assign wr_local   = accept && !write_n && (target == TGT_LOCAL);
  assign wr_upper   = accept && !write_n && (target == TGT_UPPER);
  assign rd_board   = accept &&  write_n && (target == TGT_BOARDS);
  assign sticky_set = rd_board && (sel_cnt > CNT_W'(1));
  assign sticky_clr = wr_local && (offset[1:0] == 2'd1) && wdata[0];

  always_comb begin
    rd_d = '0;
    if (target == TGT_LOCAL) begin
      unique case (offset[1:0])
        2'd0: rd_d = {{(DATA_W-NB){1'b0}}, sel_q};
        2'd1: rd_d = {{(DATA_W-1){1'b0}}, sticky_q};
        2'd2: rd_d = scratch_q;
        default: rd_d = {{(DATA_W-CNT_W){1'b0}}, sel_cnt};
      endcase
    end else if (target == TGT_UPPER) begin
      rd_d = (offset == HV_OFS) ? hv_ctl_q : clk_ctl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      sticky_q  <= 1'b0;
      scratch_q <= '0;
      clk_ctl_q <= '0;
      hv_ctl_q  <= '0;
      rd_q      <= '0;
    end else begin
      if (accept) rd_q <= write_n ? rd_d : '0;
      if (wr_local) begin
        unique case (offset[1:0])
          2'd0: sel_q <= wdata[NB-1:0];
          2'd2: scratch_q <= wdata;
          default: ;
        endcase
      end
      if (wr_upper) begin
        if (offset == HV_OFS) hv_ctl_q <= wdata;
        else                  clk_ctl_q <= wdata;
      end
      if (sticky_set)      sticky_q <= 1'b1;
      else if (sticky_clr) sticky_q <= 1'b0;
    end
  end

  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !sticky_clr) |=> sticky_q);

  assert_sticky_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sticky_q && !rd_board) |=> !sticky_q);

endmodule

// File: rtl/board_strobe_gen.sv
module board_strobe_gen
  import crate_dec_pkg::*;
#(
  parameter int NB = 18
) (
  input  logic          ack_active,
  input  target_e       tgt_q,
  input  logic [NB-1:0] sel_mask,
  output logic [NB-1:0] board_sel
);
  logic board_cycle;
  assign board_cycle = ack_active && (tgt_q == TGT_BOARDS);

  for (genvar i = 0; i < NB; i++) begin : g_strobe
    assign board_sel[i] = board_cycle && sel_mask[i];
  end

endmodule

// File: rtl/crate_slave_decoder.sv
module crate_slave_decoder
  import crate_dec_pkg::*;
#(
  parameter int NB      = 18,
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] crate_id,
  input  logic [2:0]         field_pos,
  input  logic [31:1]        addr,
  input  logic [5:0]         am,
  input  logic               as_n,
  input  logic               ds0_n,
  input  logic               ds1_n,
  input  logic               lword_n,
  input  logic               write_n,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               dtack_n,
  output logic [NB-1:0]      board_sel
);
  localparam int FIELD_BASE = 22;
  localparam int OFS_W      = FIELD_BASE - 2;
  localparam logic [OFS_W-1:0] CLK_OFS = OFS_W'('h100);
  localparam logic [OFS_W-1:0] HV_OFS  = OFS_W'('h101);
  localparam logic [5:0]       AM_MEM  = 6'h09;

  logic             qual_ok, start, accept, ack_active;
  target_e          target, tgt_q;
  logic [OFS_W-1:0] offset;
  logic [NB-1:0]    sel_mask;
  logic [DATA_W-1:0] rd_q;

  cycle_qualify #(
    .NB(NB), .FIELD_W(FIELD_W), .FIELD_BASE(FIELD_BASE), .FIELD_SPAN(10),
    .AM_CODE(AM_MEM), .LOCAL_REGS(4), .OFS_W(OFS_W),
    .CLK_OFS(CLK_OFS), .HV_OFS(HV_OFS)
  ) u_qual (
    .addr(addr), .am(am), .lword_n(lword_n), .ds0_n(ds0_n), .ds1_n(ds1_n),
    .crate_id(crate_id), .field_pos(field_pos), .sel_mask(sel_mask),
    .qual_ok(qual_ok), .target(target), .offset(offset)
  );

  bus_cycle_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds0_n(ds0_n), .ds1_n(ds1_n),
    .qual_ok(qual_ok), .target(target), .start(start), .accept(accept),
    .ack_active(ack_active), .tgt_q(tgt_q)
  );

  crate_local_regs #(
    .NB(NB), .DATA_W(DATA_W), .OFS_W(OFS_W), .HV_OFS(HV_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .target(target),
    .offset(offset), .write_n(write_n), .wdata(wdata),
    .sel_mask(sel_mask), .rd_q(rd_q)
  );

  board_strobe_gen #(.NB(NB)) u_strobe (
    .ack_active(ack_active), .tgt_q(tgt_q), .sel_mask(sel_mask),
    .board_sel(board_sel)
  );

  assign dtack_n = !ack_active;
  assign rdata   = ack_active ? rd_q : '0;

  assert_bad_am_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && am != AM_MEM) |=> dtack_n);

  assert_short_xfer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (lword_n || addr[1])) |=> dtack_n);

  assert_strobe_in_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|board_sel) |-> !dtack_n);

  assert_broadcast_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|board_sel) |-> (board_sel == sel_mask));

endmodule

// File: tb/crate_slave_decoder_bench.sv
module crate_slave_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  crate_id = 5'd9;
  logic [2:0]  field_pos = 3'd2;
  logic [31:1] addr = '0;
  logic [5:0]  am = 6'h09;
  logic        as_n = 1'b1, ds0_n = 1'b1, ds1_n = 1'b1, lword_n = 1'b1, write_n = 1'b1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dtack_n;
  logic [17:0] board_sel;

  int n_checks = 0;
  int n_errors = 0;

  crate_slave_decoder u_crate_slave_decoder (
    .clk(clk), .rst_n(rst_n), .crate_id(crate_id), .field_pos(field_pos),
    .addr(addr), .am(am), .as_n(as_n), .ds0_n(ds0_n), .ds1_n(ds1_n),
    .lword_n(lword_n), .write_n(write_n), .wdata(wdata), .rdata(rdata),
    .dtack_n(dtack_n), .board_sel(board_sel)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:1] mk(input logic [4:0] crate, input int pos, input int ofs);
    logic [31:0] v;
    int p;
    p = (pos > 5) ? 5 : pos;
    v = (32'(crate) << (22 + p)) | (32'(ofs) << 2);
    return v[31:1];
  endfunction

  logic        r_ack, r_rel;
  logic [31:0] r_data;
  logic [17:0] r_sel;

  task automatic bus_op(input logic [31:1] a, input logic [5:0] amv, input logic lw,
                        input logic d0, input logic d1, input logic wr, input logic [31:0] wd);
    @(negedge clk);
    addr = a; am = amv; lword_n = lw; write_n = !wr; wdata = wd;
    as_n = 1'b0; ds0_n = d0; ds1_n = d1;
    @(negedge clk);
    r_ack = !dtack_n; r_data = rdata; r_sel = board_sel;
    @(negedge clk);
    ds0_n = 1'b1; ds1_n = 1'b1;
    @(negedge clk);
    r_rel = dtack_n;
    as_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int ofs, input logic [31:0] d);
    bus_op(mk(crate_id, field_pos, ofs), 6'h09, 1'b0, 1'b0, 1'b0, 1'b1, d);
  endtask

  task automatic rd(input int ofs);
    bus_op(mk(crate_id, field_pos, ofs), 6'h09, 1'b0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_reset;
    chk("R4 dtack idle after reset", 32'(dtack_n), 32'd1);
    chk("R8 no strobe after reset", 32'(board_sel), 32'd0);
    chk("R11 rdata zero when idle", rdata, 32'd0);
    rd(0);
    chk("R5 mask reset value", r_data, 32'd0);
  endtask

  task automatic t_handshake;
    wr(0, 32'h0000_0005);
    chk("R4 dtack after start", 32'(r_ack), 32'd1);
    chk("R4 dtack released after strobe", 32'(r_rel), 32'd1);
    rd(0);
    chk("R5 mask readback", r_data, 32'h5);
    wr(2, 32'hCAFE_F00D);
    rd(2);
    chk("R11 scratch readback", r_data, 32'hCAFE_F00D);
    rd(3);
    chk("R11 mask population count", r_data, 32'd2);
  endtask

  task automatic t_reject;
    bus_op(mk(crate_id, field_pos, 0), 6'h09, 1'b1, 1'b0, 1'b0, 1'b1, 32'h3FFFF);
    chk("R1 word transfer ignored", 32'(r_ack), 32'd0);
    bus_op(mk(crate_id, field_pos, 0), 6'h09, 1'b0, 1'b0, 1'b1, 1'b1, 32'h3FFFF);
    chk("R1 single strobe ignored", 32'(r_ack), 32'd0);
    bus_op(mk(crate_id, field_pos, 0) | 31'h1, 6'h09, 1'b0, 1'b0, 1'b0, 1'b1, 32'h3FFFF);
    chk("R1 A1 set ignored", 32'(r_ack), 32'd0);
    bus_op(mk(crate_id, field_pos, 0), 6'h0D, 1'b0, 1'b0, 1'b0, 1'b1, 32'h3FFFF);
    chk("R2 other AM ignored", 32'(r_ack), 32'd0);
    bus_op(mk(5'd10, field_pos, 0), 6'h09, 1'b0, 1'b0, 1'b0, 1'b1, 32'h3FFFF);
    chk("R3 other crate ignored", 32'(r_ack), 32'd0);
    rd(0);
    chk("R2 mask untouched by ignored writes", r_data, 32'h5);
  endtask

  task automatic t_field_pos;
    field_pos = 3'd4;
    rd(0);
    chk("R3 field at position 4", 32'(r_ack), 32'd1);
    bus_op(mk(crate_id, 2, 0), 6'h09, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R3 old position misses", 32'(r_ack), 32'd0);
    field_pos = 3'd7;
    rd(0);
    chk("R3 position above 5 clamps", 32'(r_ack), 32'd1);
    field_pos = 3'd2;
  endtask

  task automatic t_boards;
    wr(0, 32'h0000_0004);
    wr(32, 32'h1234);
    chk("R8 single board ack", 32'(r_ack), 32'd1);
    chk("R8 single board strobe", 32'(r_sel), 32'h4);
    wr(2, 32'h1);
    chk("R6 local offset no strobe", 32'(r_sel), 32'd0);
    wr(0, 32'h0);
    wr(32, 32'h1);
    chk("R8 empty mask no ack", 32'(r_ack), 32'd0);
    rd(1);
    chk("R6 local answers with empty mask", 32'(r_ack), 32'd1);
    wr(0, 32'h0FFFF);
    wr(64, 32'hABCD);
    chk("R9 broadcast strobes all", 32'(r_sel), 32'h0FFFF);
  endtask

  task automatic t_upper;
    wr(256, 32'h77);
    chk("R7 clock word needs bit 17", 32'(r_ack), 32'd0);
    wr(0, 32'h20003);
    wr(256, 32'h77);
    chk("R7 clock word with bit 17", 32'(r_ack), 32'd1);
    chk("R7 upper no board strobe", 32'(r_sel), 32'd0);
    wr(257, 32'h55AA);
    rd(256);
    chk("R7 clock word readback", r_data, 32'h77);
    rd(257);
    chk("R7 hv word readback", r_data, 32'h55AA);
    wr(0, 32'h3);
    wr(257, 32'h0);
    wr(0, 32'h20000);
    rd(257);
    chk("R7 write without bit 17 dropped", r_data, 32'h55AA);
  endtask

  task automatic t_sticky;
    wr(0, 32'h1);
    rd(40);
    rd(1);
    chk("R10 single select no flag", r_data, 32'd0);
    wr(0, 32'h3);
    rd(40);
    chk("R11 board read gives zero data", r_data, 32'd0);
    rd(1);
    chk("R10 multi read sets flag", r_data, 32'd1);
    wr(40, 32'h9);
    rd(1);
    chk("R10 flag sticky", r_data, 32'd1);
    wr(1, 32'h0);
    rd(1);
    chk("R10 write zero keeps flag", r_data, 32'd1);
    wr(1, 32'h1);
    rd(1);
    chk("R10 flag cleared", r_data, 32'd0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_handshake();
    t_reject();
    t_field_pos();
    t_boards();
    t_upper();
    t_sticky();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule